// File: doc/BRIEF.md
# USB Host Port Command and Interrupt Register Block

This block is the software-facing control and event side of a USB host port. Software sees three 8-bit registers over a simple single-cycle write port and a combinational read port. The control register holds a frame-generation enable and two command bits, bus reset and resume. Each command bit sets itself on a software write of 1. It stays set until a bus sequencer reports that the command has finished, and a software write of 0 cannot clear it. While a command is starting, the block sends the sequencer a one-cycle request strobe. It then waits in a named state for the matching done pulse.

The event register collects flags that hardware sets from bus events, completed commands and frame ticks. Software clears a flag by writing 0 to it, and a written 1 leaves the flag unchanged. An enable register with the same bit layout selects which flags drive the single interrupt output. A frame timer issues a tick every `FRAME_CYCLES` clocks while frame generation is on. The tick leaves as a start-of-frame strobe at full speed, or as a keep-alive strobe when the low-speed input is high.

The command sequencer has three states. `CMD_IDLE` leaves for `CMD_RST_WAIT` on a reset write, or for `CMD_RSM_WAIT` on an accepted resume write. `CMD_RST_WAIT` returns to `CMD_IDLE` on `reset_done`, and `CMD_RSM_WAIT` returns to `CMD_IDLE` on `resume_done`.

Top module: `usb_hc_regs`

## Requirements
- R1: After reset every register reads 0x00, and all outputs are 0. The control register at address 0 reads 0 in bits 7:3. The event register at address 1 and the enable register at address 2 read 0 in bit 7. Address 3 reads 0x00. Writes to reserved bits have no effect.
- R2: Control bit 0 (frame enable) is read/write. While it is 1, exactly one frame tick is issued every `FRAME_CYCLES` clocks. While it is 0, no tick is issued.
- R3: When `low_speed` is 0, each tick appears on `sof_strobe`. When `low_speed` is 1, each tick appears on `keepalive_strobe`. Either kind of tick sets event bit 5.
- R4: A write of 1 to control bit 1 (bus reset) while idle sets that bit and gives a one-cycle `req_reset` in the next cycle. The bit stays 1 through later writes of 0 and is cleared only by `reset_done`.
- R5: A write of 1 to control bit 2 (resume) is accepted only if the same write sets bit 0 to 1. When accepted, it sets the bit and gives a one-cycle `req_resume`. The bit is cleared only by `resume_done`. A resume write with bit 0 equal to 0 has no effect.
- R6: A write that sets both bit 1 and bit 2 starts only the bus reset. A command write made while a command is pending has no effect on the command bits.
- R7: `reset_done` sets event bit 2 and `resume_done` sets event bit 3, but only while the matching command is pending. A done pulse that arrives with no matching command pending is ignored.
- R8: These bus event inputs set event bits: `bus_nonidle` sets bit 6, `rmt_resume` sets bit 4, `dev_disconnect` sets bit 1, and `dev_connect` sets bit 0.
- R9: Writing 0 to an event bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the bit at 1.
- R10: `irq` is 1 exactly when some event bit and the bit of the same position in the enable register are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 events, 2 enables |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| low_speed | input | 1 | 1 selects keep-alive ticks instead of start-of-frame |
| reset_done | input | 1 | Sequencer pulse: bus reset finished |
| resume_done | input | 1 | Sequencer pulse: resume finished |
| bus_nonidle | input | 1 | Pulse: non-idle bus state seen |
| rmt_resume | input | 1 | Pulse: remote resume received |
| dev_disconnect | input | 1 | Pulse: device detached |
| dev_connect | input | 1 | Pulse: device attached |
| req_reset | output | 1 | One-cycle request to drive a bus reset |
| req_resume | output | 1 | One-cycle request to drive a resume |
| sof_strobe | output | 1 | One-cycle start-of-frame tick |
| keepalive_strobe | output | 1 | One-cycle low-speed keep-alive tick |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench tries to clear the command bits with writes of 0. A design that let software cancel a command would show a cleared bit before the done pulse arrives. It sends done pulses with no command pending, and it sends resume writes with frame generation off. A block that latched these would set event flags or issue requests nobody asked for. It clears an event flag in the same cycle that hardware sets it, where a wrong write priority would lose the event. It also counts ticks over several frame periods at both speeds, which catches an off-by-one period and a strobe routed to the wrong output.

// File: rtl/usb_hc_pkg.sv
package usb_hc_pkg;

    localparam int REG_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_ENA  = 2'd2;

    localparam int CTL_FRAME_EN = 0;
    localparam int CTL_BUS_RST  = 1;
    localparam int CTL_RESUME   = 2;

    localparam int EVT_BITS     = 7;
    localparam int EVT_CONNECT  = 0;
    localparam int EVT_DISCON   = 1;
    localparam int EVT_RST_SENT = 2;
    localparam int EVT_RSM_SENT = 3;
    localparam int EVT_RMT_RSM  = 4;
    localparam int EVT_FRAME    = 5;
    localparam int EVT_WAKE     = 6;

    typedef enum logic [1:0] {
        CMD_IDLE     = 2'd0,
        CMD_RST_WAIT = 2'd1,
        CMD_RSM_WAIT = 2'd2
    } cmd_state_t;

endpackage

// File: rtl/usb_hc_frame_timer.sv
module usb_hc_frame_timer #(
    parameter int FRAME_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int CNT_W = $clog2(FRAME_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R2: a tick is only issued while frame generation has been on
    a_r2_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(enable));

    // R2: ticks are never back to back unless the period is one clock
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && FRAME_CYCLES > 1) |=> !tick);

endmodule

// File: rtl/usb_hc_cmd_seq.sv
module usb_hc_cmd_seq
    import usb_hc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic wr_reset,
    input  logic wr_resume,
    input  logic wr_frame_en,
    input  logic reset_done,
    input  logic resume_done,
    output logic reset_busy,
    output logic resume_busy,
    output logic req_reset,
    output logic req_resume,
    output logic reset_sent,
    output logic resume_sent
);
    cmd_state_t state, state_nx;
    logic go_reset, go_resume;

    always_comb begin
        go_reset  = 1'b0;
        go_resume = 1'b0;
        state_nx  = state;
        unique case (state)
            CMD_IDLE: begin
                if (ctrl_we && wr_reset) begin
                    go_reset = 1'b1;
                    state_nx = CMD_RST_WAIT;
                end else if (ctrl_we && wr_resume && wr_frame_en) begin
                    go_resume = 1'b1;
                    state_nx  = CMD_RSM_WAIT;
                end
            end
            CMD_RST_WAIT: if (reset_done)  state_nx = CMD_IDLE;
            CMD_RSM_WAIT: if (resume_done) state_nx = CMD_IDLE;
            default:      state_nx = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CMD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_reset  <= 1'b0;
            req_resume <= 1'b0;
        end else begin
            req_reset  <= go_reset;
            req_resume <= go_resume;
        end
    end

    assign reset_busy  = (state == CMD_RST_WAIT);
    assign resume_busy = (state == CMD_RSM_WAIT);
    assign reset_sent  = reset_busy && reset_done;
    assign resume_sent = resume_busy && resume_done;

    // R6: the two request strobes never overlap
    a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_reset, req_resume}));

    // R4: a pending reset holds until its done pulse
    a_r4_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_busy && !reset_done) |=> reset_busy);

    // R5: a pending resume holds until its done pulse
    a_r5_resume_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_busy && !resume_done) |=> resume_busy);

    // R4: a reset request comes with the bit already set
    a_r4_req_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |-> reset_busy);

endmodule

// File: rtl/usb_hc_irq_regs.sv
module usb_hc_irq_regs
    import usb_hc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_we,
    input  logic                ena_we,
    input  logic [REG_W-1:0]    wdata,
    input  logic [EVT_BITS-1:0] hw_set,
    output logic [EVT_BITS-1:0] flags,
    output logic [EVT_BITS-1:0] enables,
    output logic                irq
);
    logic unused_wbit;
    assign unused_wbit = wdata[REG_W-1];

    for (genvar i = 0; i < EVT_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)             flags[i] <= 1'b0;
            else if (hw_set[i])     flags[i] <= 1'b1;
            else if (evt_we && !wdata[i]) flags[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)      enables[i] <= 1'b0;
            else if (ena_we) enables[i] <= wdata[i];
        end

        // R9: a hardware set is never lost, even against a software clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> flags[i]);

        // R9: a flag only rises through a hardware set
        a_r9_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(hw_set[i]));
    end

    assign irq = |(flags & enables);

endmodule

// File: rtl/usb_hc_regs.sv
module usb_hc_regs
    import usb_hc_pkg::*;
#(
    parameter int FRAME_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             low_speed,
    input  logic             reset_done,
    input  logic             resume_done,
    input  logic             bus_nonidle,
    input  logic             rmt_resume,
    input  logic             dev_disconnect,
    input  logic             dev_connect,
    output logic             req_reset,
    output logic             req_resume,
    output logic             sof_strobe,
    output logic             keepalive_strobe,
    output logic             irq
);
    logic frame_en, tick;
    logic reset_busy, resume_busy, reset_sent, resume_sent;
    logic ctrl_we, evt_we, ena_we;
    logic [EVT_BITS-1:0] hw_set, flags, enables;

    assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);
    assign evt_we  = reg_we && (reg_addr == ADDR_EVT);
    assign ena_we  = reg_we && (reg_addr == ADDR_ENA);

    always_ff @(posedge clk) begin
        if (!rst_n)       frame_en <= 1'b0;
        else if (ctrl_we) frame_en <= reg_wdata[CTL_FRAME_EN];
    end

    usb_hc_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (frame_en),
        .tick   (tick)
    );

    usb_hc_cmd_seq u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .wr_reset    (reg_wdata[CTL_BUS_RST]),
        .wr_resume   (reg_wdata[CTL_RESUME]),
        .wr_frame_en (reg_wdata[CTL_FRAME_EN]),
        .reset_done  (reset_done),
        .resume_done (resume_done),
        .reset_busy  (reset_busy),
        .resume_busy (resume_busy),
        .req_reset   (req_reset),
        .req_resume  (req_resume),
        .reset_sent  (reset_sent),
        .resume_sent (resume_sent)
    );

    always_comb begin
        hw_set               = '0;
        hw_set[EVT_CONNECT]  = dev_connect;
        hw_set[EVT_DISCON]   = dev_disconnect;
        hw_set[EVT_RST_SENT] = reset_sent;
        hw_set[EVT_RSM_SENT] = resume_sent;
        hw_set[EVT_RMT_RSM]  = rmt_resume;
        hw_set[EVT_FRAME]    = tick;
        hw_set[EVT_WAKE]     = bus_nonidle;
    end

    usb_hc_irq_regs u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_we  (evt_we),
        .ena_we  (ena_we),
        .wdata   (reg_wdata),
        .hw_set  (hw_set),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );

    assign sof_strobe       = tick && !low_speed;
    assign keepalive_strobe = tick && low_speed;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTL_FRAME_EN] = frame_en;
                reg_rdata[CTL_BUS_RST]  = reset_busy;
                reg_rdata[CTL_RESUME]   = resume_busy;
            end
            ADDR_EVT: reg_rdata[EVT_BITS-1:0] = flags;
            ADDR_ENA: reg_rdata[EVT_BITS-1:0] = enables;
            default:  reg_rdata = '0;
        endcase
    end

    // R3: start-of-frame and keep-alive strobes never overlap
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_strobe && keepalive_strobe));

    // R5: a resume request only goes out with frame generation on
    a_r5_resume_needs_frames: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> frame_en);

    // R1: control reserved bits always read zero
    a_r1_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (reg_rdata[REG_W-1:3] == '0));

endmodule

// File: tb/tb_usb_hc_regs.sv
module tb_usb_hc_regs;
    localparam int FC = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic [1:0] reg_addr = 0;
    logic reg_we = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic low_speed = 0, reset_done = 0, resume_done = 0;
    logic bus_nonidle = 0, rmt_resume = 0, dev_disconnect = 0, dev_connect = 0;
    logic req_reset, req_resume, sof_strobe, keepalive_strobe, irq;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    usb_hc_regs #(.FRAME_CYCLES(FC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .low_speed(low_speed),
        .reset_done(reset_done), .resume_done(resume_done),
        .bus_nonidle(bus_nonidle), .rmt_resume(rmt_resume),
        .dev_disconnect(dev_disconnect), .dev_connect(dev_connect),
        .req_reset(req_reset), .req_resume(req_resume),
        .sof_strobe(sof_strobe), .keepalive_strobe(keepalive_strobe), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk); @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 8'h00, "R1 reset value", d, 0);
        end
        check({req_reset, req_resume, sof_strobe, keepalive_strobe, irq} == 0,
              "R1 outputs at reset", {req_reset, req_resume, sof_strobe, keepalive_strobe, irq}, 0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(0, 8'hF8); rd(0, d); check(d == 8'h00, "R1 ctrl reserved", d, 0);
        wr(2, 8'hFF); rd(2, d); check(d == 8'h7F, "R1 enable reserved", d, 8'h7F);
        wr(2, 8'h00);
        wr(3, 8'hFF); rd(3, d); check(d == 8'h00, "R1 unused address", d, 0);
    endtask

    task automatic t_frames(input logic ls);
        int ns = 0, nk = 0;
        logic [7:0] d;
        low_speed = ls;
        wr(0, 8'h01);
        rd(0, d); check(d == 8'h01, "R2 frame enable readback", d, 1);
        repeat (4 * FC) begin
            @(negedge clk);
            ns += int'(sof_strobe); nk += int'(keepalive_strobe);
        end
        check(ns == (ls ? 0 : 4), "R3 sof strobe count", ns, ls ? 0 : 4);
        check(nk == (ls ? 4 : 0), "R3 keepalive count", nk, ls ? 4 : 0);
        rd(1, d); check(d[5] == 1'b1, "R3 frame flag set", d, 8'h20);
        wr(0, 8'h00); wr(1, 8'h00);
        ns = 0;
        repeat (3 * FC) begin
            @(negedge clk);
            ns += int'(sof_strobe) + int'(keepalive_strobe);
        end
        check(ns == 0, "R2 no ticks when disabled", ns, 0);
        rd(1, d); check(d[5] == 1'b0, "R2 frame flag stays clear", d, 0);
        low_speed = 0;
    endtask

    task automatic t_bus_reset();
        logic [7:0] d;
        wr(0, 8'h02);
        check(req_reset == 1'b1, "R4 request strobe", req_reset, 1);
        rd(0, d); check(d == 8'h02, "R4 bit set", d, 2);
        idle(1);
        check(req_reset == 1'b0, "R4 strobe one cycle", req_reset, 0);
        wr(0, 8'h00); rd(0, d); check(d == 8'h02, "R4 soft clear ignored", d, 2);
        wr(0, 8'h04); rd(0, d); check(d == 8'h02 && !req_resume, "R6 write while busy", d, 2);
        reset_done = 1; @(posedge clk); @(negedge clk); reset_done = 0;
        rd(0, d); check(d == 8'h00, "R4 cleared by done", d, 0);
        rd(1, d); check(d == 8'h04, "R7 reset sent flag", d, 4);
        wr(1, 8'h00);
    endtask

    task automatic t_resume();
        logic [7:0] d;
        wr(0, 8'h04);
        check(req_resume == 1'b0, "R5 no request without frames", req_resume, 0);
        rd(0, d); check(d == 8'h00, "R5 ignored without frames", d, 0);
        wr(0, 8'h05);
        check(req_resume == 1'b1, "R5 request strobe", req_resume, 1);
        rd(0, d); check(d == 8'h05, "R5 bit set", d, 5);
        wr(0, 8'h01); rd(0, d); check(d == 8'h05, "R5 soft clear ignored", d, 5);
        reset_done = 1; @(posedge clk); @(negedge clk); reset_done = 0;
        rd(1, d); check(d[2] == 1'b0, "R7 stray reset done ignored", d, 0);
        resume_done = 1; @(posedge clk); @(negedge clk); resume_done = 0;
        rd(0, d); check(d == 8'h01, "R5 cleared by done", d, 1);
        rd(1, d); check(d[3] == 1'b1, "R7 resume sent flag", d, 8);
        wr(0, 8'h00); wr(1, 8'h00);
        resume_done = 1; @(posedge clk); @(negedge clk); resume_done = 0;
        rd(1, d); check(d == 8'h00, "R7 stray resume done ignored", d, 0);
    endtask

    task automatic t_both();
        logic [7:0] d;
        wr(0, 8'h06);
        check(req_reset && !req_resume, "R6 reset takes priority",
              {req_reset, req_resume}, 2);
        rd(0, d); check(d == 8'h02, "R6 only reset pending", d, 2);
        reset_done = 1; @(posedge clk); @(negedge clk); reset_done = 0;
        wr(1, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] d;
        bus_nonidle = 1; rmt_resume = 1; dev_disconnect = 1; dev_connect = 1;
        @(posedge clk); @(negedge clk);
        bus_nonidle = 0; rmt_resume = 0; dev_disconnect = 0; dev_connect = 0;
        rd(1, d); check(d == 8'h53, "R8 bus event flags", d, 8'h53);
        wr(1, 8'hFF); rd(1, d); check(d == 8'h53, "R9 write one keeps", d, 8'h53);
        wr(1, 8'hFE); rd(1, d); check(d == 8'h52, "R9 write zero clears", d, 8'h52);
        dev_connect = 1; reg_addr = 1; reg_wdata = 8'h00; reg_we = 1;
        @(posedge clk); @(negedge clk);
        reg_we = 0; dev_connect = 0;
        rd(1, d); check(d == 8'h01, "R9 set wins over clear", d, 1);
        wr(1, 8'h00);
        wr(1, 8'h7F); rd(1, d); check(d == 8'h00, "R9 soft set ignored", d, 0);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(2, 8'h02);
        dev_connect = 1; @(posedge clk); @(negedge clk); dev_connect = 0;
        check(irq == 1'b0, "R10 masked flag", irq, 0);
        dev_disconnect = 1; @(posedge clk); @(negedge clk); dev_disconnect = 0;
        check(irq == 1'b1, "R10 enabled flag", irq, 1);
        wr(1, 8'hFD);
        check(irq == 1'b0, "R10 cleared flag", irq, 0);
        wr(2, 8'h01);
        check(irq == 1'b1, "R10 enable late", irq, 1);
        rd(2, d); check(d == 8'h01, "R10 enable readback", d, 1);
        wr(1, 8'h00); wr(2, 8'h00);
    endtask

    initial begin
        fork
            begin
                idle(3); rst_n = 1; idle(1);
                t_reset_state();
                t_reserved();
                t_frames(1'b0);
                t_frames(1'b1);
                t_bus_reset();
                t_resume();
                t_both();
                t_events();
                t_irq();
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule